// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This block compares two 64-bit IEEE-754 binary64 operands. It performs one of three relations: equal, less-than or less-or-equal. An operation code and an input strobe arrive with the operands. One clock later the block returns a one-bit answer, widened with zeros to the integer register width, together with a one-cycle output strobe. It also returns a 5-bit accrued exception vector in which only the invalid-operation bit can ever be set.

The operands follow sign-magnitude order, so the two zeros are equal and infinities are ordinary ordered values. A NaN in either operand makes every comparison false. Whether the invalid flag is raised then depends on the relation. The equality relation signals only for signaling NaNs. The two ordering relations signal for any NaN, quiet or signaling.

Top module: `fp_cmp_unit`

## Requirements
- R1: When both operands are non-NaN and numerically equal, code 10 (equal) and code 00 (less-or-equal) return 1 and code 01 (less-than) returns 0.
- R2: When non-NaN operand A is strictly below operand B (e.g. -1.37 against -1.36), equal returns 0 while less-than and less-or-equal return 1; when A is strictly above B all three return 0.
- R3: Ordering is sign-magnitude: among two negative operands the one with the larger magnitude is smaller, and every negative non-zero value is below every positive value.
- R4: +0 and -0 compare equal, and neither is less than the other.
- R5: Infinities are ordered values: +inf equals +inf, -inf is below every finite value and +inf is above every finite value.
- R6: A NaN is an operand whose exponent bits [62:52] are all ones and whose fraction bits [51:0] are not all zero. When either operand is a NaN, including both, the result is 0 for every operation.
- R7: For the equal operation, the invalid flag (bit 4 of the flag vector, value 0x10) is set only if at least one operand is a signaling NaN (fraction bit 51 clear). A quiet NaN (fraction bit 51 set) gives result 0 and flags 0x00.
- R8: For less-than and less-or-equal, the invalid flag (0x10) is set whenever either operand is any NaN.
- R9: Operation code 11 returns result 0 and flags 0x00 for all operands.
- R10: Result and flags appear in the cycle after a valid input, with the output strobe high for exactly that cycle. Reset clears the strobe. Flag bits other than bit 4 are always 0, and result bits above bit 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op_sel | input | 2 | 00 less-or-equal, 01 less-than, 10 equal, 11 reserved |
| opa | input | 64 | Operand A, binary64 |
| opb | input | 64 | Operand B, binary64 |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Comparison outcome in bit 0, upper bits zero |
| flags | output | 5 | Accrued exceptions; bit 4 is invalid-operation |

## Verification
The result decision and the invalid-flag decision are taken in the same cycle from the same NaN classification. A NaN input can therefore zero the result and raise the flag at once, or zero the result while the flag stays clear. The sweep drives every pair from a set of sixteen special and ordinary values under all four operation codes. This includes quiet and signaling NaNs of both signs against each other and against numbers. In each case the bench checks result and flag together against a model built from real-number comparison and a separate bitwise NaN test. A mismatch in either half of a combination is therefore reported against the requirement for that combination.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   typedef enum logic [1:0] {
      CMP_LE  = 2'b00,
      CMP_LT  = 2'b01,
      CMP_EQ  = 2'b10,
      CMP_RSV = 2'b11
   } cmp_op_e;

   localparam int unsigned DEF_EXP_W   = 11;
   localparam int unsigned DEF_FRAC_W  = 52;
   localparam int unsigned DEF_XLEN    = 64;
   localparam int unsigned DEF_FLAG_W  = 5;
   localparam int unsigned DEF_INV_POS = 4;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int unsigned EXP_W  = 11,
   parameter int unsigned FRAC_W = 52,
   localparam int unsigned WORD_W = EXP_W + FRAC_W + 1,
   localparam int unsigned MAG_W  = EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] word,
   output logic              sign,
   output logic              is_nan,
   output logic              is_snan,
   output logic              is_zero,
   output logic [MAG_W-1:0]  mag
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              frac_nz;

   always_comb begin
      sign     = word[WORD_W-1];
      exp_f    = word[WORD_W-2:FRAC_W];
      frac_f   = word[FRAC_W-1:0];
      mag      = word[MAG_W-1:0];
      exp_ones = &exp_f;
      frac_nz  = |frac_f;
      is_nan   = exp_ones & frac_nz;
      is_snan  = is_nan & ~frac_f[FRAC_W-1];
      is_zero  = ~|mag;
   end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
   parameter int unsigned MAG_W = 63
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             eq,
   output logic             lt
);

   logic both_zero;
   logic mag_lt;
   logic mag_gt;

   always_comb begin
      both_zero = zero_a & zero_b;
      mag_lt    = mag_a < mag_b;
      mag_gt    = mag_a > mag_b;
      eq        = both_zero | ((sign_a == sign_b) & (mag_a == mag_b));
      if (both_zero)
         lt = 1'b0;
      else if (sign_a != sign_b)
         lt = sign_a;
      else if (!sign_a)
         lt = mag_lt;
      else
         lt = mag_gt;
   end

endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
   import fpcmp_pkg::*;
(
   input  logic [1:0] op_sel,
   input  logic       eq,
   input  logic       lt,
   input  logic       nan_a,
   input  logic       nan_b,
   input  logic       snan_a,
   input  logic       snan_b,
   output logic       res,
   output logic       invalid
);

   logic    any_nan;
   logic    any_snan;
   cmp_op_e op;

   always_comb begin
      op       = cmp_op_e'(op_sel);
      any_nan  = nan_a | nan_b;
      any_snan = snan_a | snan_b;
      res      = 1'b0;
      invalid  = 1'b0;
      unique case (op)
         CMP_LE: begin
            res     = ~any_nan & (lt | eq);
            invalid = any_nan;
         end
         CMP_LT: begin
            res     = ~any_nan & lt;
            invalid = any_nan;
         end
         CMP_EQ: begin
            res     = ~any_nan & eq;
            invalid = any_snan;
         end
         default: begin
            res     = 1'b0;
            invalid = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit #(
   parameter int unsigned EXP_W   = fpcmp_pkg::DEF_EXP_W,
   parameter int unsigned FRAC_W  = fpcmp_pkg::DEF_FRAC_W,
   parameter int unsigned XLEN    = fpcmp_pkg::DEF_XLEN,
   parameter int unsigned FLAG_W  = fpcmp_pkg::DEF_FLAG_W,
   parameter int unsigned INV_POS = fpcmp_pkg::DEF_INV_POS,
   localparam int unsigned WORD_W = EXP_W + FRAC_W + 1,
   localparam int unsigned MAG_W  = EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op_sel,
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   output logic              out_valid,
   output logic [XLEN-1:0]   result,
   output logic [FLAG_W-1:0] flags
);

   localparam int unsigned NOPS = 2;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fp_cmp_unit: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fp_cmp_unit: FRAC_W must be at least 2");
   end
   if (XLEN < 2) begin : g_bad_xlen
      $error("fp_cmp_unit: XLEN must be at least 2");
   end
   if (INV_POS >= FLAG_W) begin : g_bad_flag
      $error("fp_cmp_unit: INV_POS must lie inside the flag vector");
   end

   logic [WORD_W-1:0] words   [NOPS];
   logic              sgn     [NOPS];
   logic              nan     [NOPS];
   logic              snan    [NOPS];
   logic              zro     [NOPS];
   logic [MAG_W-1:0]  mag     [NOPS];

   assign words[0] = opa;
   assign words[1] = opb;

   for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
      fpcmp_classify #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_cls (
         .word    (words[gi]),
         .sign    (sgn[gi]),
         .is_nan  (nan[gi]),
         .is_snan (snan[gi]),
         .is_zero (zro[gi]),
         .mag     (mag[gi])
      );
   end

   logic rel_eq;
   logic rel_lt;

   fpcmp_order #(
      .MAG_W (MAG_W)
   ) u_ord (
      .sign_a (sgn[0]),
      .sign_b (sgn[1]),
      .zero_a (zro[0]),
      .zero_b (zro[1]),
      .mag_a  (mag[0]),
      .mag_b  (mag[1]),
      .eq     (rel_eq),
      .lt     (rel_lt)
   );

   logic res_d;
   logic inv_d;

   fpcmp_decide u_dec (
      .op_sel  (op_sel),
      .eq      (rel_eq),
      .lt      (rel_lt),
      .nan_a   (nan[0]),
      .nan_b   (nan[1]),
      .snan_a  (snan[0]),
      .snan_b  (snan[1]),
      .res     (res_d),
      .invalid (inv_d)
   );

   logic              vld_q;
   logic              res_q;
   logic [FLAG_W-1:0] flg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= 1'b0;
         flg_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            res_q <= res_d;
            flg_q <= FLAG_W'(inv_d) << INV_POS;
         end
      end
   end

   assign out_valid = vld_q;
   assign result    = {{(XLEN-1){1'b0}}, res_q};
   assign flags     = flg_q;

endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk #(
   parameter int unsigned EXP_W   = 11,
   parameter int unsigned FRAC_W  = 52,
   parameter int unsigned XLEN    = 64,
   parameter int unsigned FLAG_W  = 5,
   parameter int unsigned INV_POS = 4,
   localparam int unsigned WORD_W = EXP_W + FRAC_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        op_sel,
   input logic [WORD_W-1:0] opa,
   input logic [WORD_W-1:0] opb,
   input logic              out_valid,
   input logic [XLEN-1:0]   result,
   input logic [FLAG_W-1:0] flags
);

   localparam logic [FLAG_W-1:0] INV_MASK = FLAG_W'(1) << INV_POS;

   function automatic logic w_nan(input logic [WORD_W-1:0] w);
      return (&w[WORD_W-2:FRAC_W]) & (|w[FRAC_W-1:0]);
   endfunction

   function automatic logic w_snan(input logic [WORD_W-1:0] w);
      return w_nan(w) & ~w[FRAC_W-1];
   endfunction

   logic any_nan;
   logic any_snan;
   assign any_nan  = w_nan(opa) | w_nan(opb);
   assign any_snan = w_snan(opa) | w_snan(opb);

   // R10
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (result[XLEN-1:1] == '0));

   // R10
   flag_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((flags & ~INV_MASK) == '0));

   // R6
   nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_nan) |=> (result == '0));

   // R8
   ord_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_nan && (op_sel == 2'b00 || op_sel == 2'b01)) |=> flags[INV_POS]);

   // R7
   eq_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b10 && !any_snan) |=> !flags[INV_POS]);

   // R9
   rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b11) |=> (result == '0 && flags == '0));

endmodule

bind fp_cmp_unit fp_cmp_unit_chk #(
   .EXP_W   (EXP_W),
   .FRAC_W  (FRAC_W),
   .XLEN    (XLEN),
   .FLAG_W  (FLAG_W),
   .INV_POS (INV_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .opa       (opa),
   .opb       (opb),
   .out_valid (out_valid),
   .result    (result),
   .flags     (flags)
);

// File: tb/fp_cmp_unit_tb.sv
module fp_cmp_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [63:0] result;
   logic [4:0]  flags;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fp_cmp_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sel    (op_sel),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result),
      .flags     (flags)
   );

   function automatic logic [63:0] pick(input int i);
      case (i)
         0:  return 64'h0000000000000000; // +0
         1:  return 64'h8000000000000000; // -0
         2:  return 64'h3FF0000000000000; // 1.0
         3:  return 64'hBFF0000000000000; // -1.0
         4:  return 64'hBFF5C28F5C28F5C3; // -1.36
         5:  return 64'hBFF5EB851EB851EC; // -1.37
         6:  return 64'h4004000000000000; // 2.5
         7:  return 64'h7FEFFFFFFFFFFFFF; // max finite
         8:  return 64'h0000000000000001; // min subnormal
         9:  return 64'h8000000000000001; // -min subnormal
         10: return 64'h7FF0000000000000; // +inf
         11: return 64'hFFF0000000000000; // -inf
         12: return 64'h7FF8000000000000; // qNaN
         13: return 64'hFFF8000000000005; // -qNaN
         14: return 64'h7FF0000000000001; // sNaN
         default: return 64'hFFF4000000000000; // -sNaN
      endcase
   endfunction

   function automatic bit is_nan(input logic [63:0] w);
      return (w[62:52] == 11'h7FF) && (w[51:0] != '0);
   endfunction

   function automatic bit is_snan(input logic [63:0] w);
      return is_nan(w) && !w[51];
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic run_one(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op);
      bit    nn, sn, er, ei;
      real   ra, rb;
      string tag;
      nn = is_nan(a) || is_nan(b);
      sn = is_snan(a) || is_snan(b);
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      er = 1'b0;
      ei = 1'b0;
      if (op == 2'b11) begin
         tag = "R9";
      end else if (nn) begin
         ei  = (op == 2'b10) ? sn : 1'b1;
         tag = (op == 2'b10) ? "R6,R7" : "R6,R8";
      end else begin
         case (op)
            2'b00:   er = (ra <= rb);
            2'b01:   er = (ra < rb);
            default: er = (ra == rb);
         endcase
         if (a[62:0] == '0 && b[62:0] == '0)       tag = "R4";
         else if (a[62:52] == 11'h7FF || b[62:52] == 11'h7FF) tag = "R5";
         else if (ra == rb)                         tag = "R1";
         else if (a[63] || b[63])                   tag = "R3";
         else                                       tag = "R2";
      end
      @(negedge clk);
      opa      = a;
      opb      = b;
      op_sel   = op;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10", "out_valid", 64'(out_valid), 64'd1);
      chk(tag, $sformatf("result a=%h b=%h op=%0d", a, b, op), result, 64'(er));
      chk(tag, $sformatf("flags a=%h b=%h op=%0d", a, b, op), 64'(flags), 64'(ei) << 4);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "out_valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "out_valid after reset", 64'(out_valid), 64'd0);

      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            for (int k = 0; k < 4; k++) begin
               run_one(pick(i), pick(j), 2'(k));
            end
         end
      end

      // R10: strobe lasts exactly one cycle
      @(negedge clk);
      chk("R10", "out_valid idle", 64'(out_valid), 64'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule